// File: doc/BRIEF.md
# Configurable Serial Frame Transmitter

This block turns one data word into a serial frame on a single output line. In asynchronous mode a frame holds a low start bit, then 7, 8 or 9 data bits sent least significant bit first, then an optional parity bit of odd or even sense, then one or two high stop bits. In clock-synchronous mode the block shifts out eight data bits with no framing bits and drives a shift clock alongside them. The clock idles high, and the data changes on its falling edge.

A client presents a word on `ld_data` and raises `ld_valid` while `busy` is low. The word and the mode inputs are captured on that clock edge. After that, the frame advances only on cycles where the external bit-rate enable `bit_tick` is high. An asynchronous bit lasts one tick period. In synchronous mode each tick moves the shift clock by one half period. `busy` stays high until the frame is complete, and a load offered while it is high is dropped.

Top module: `serial_frame_tx`

## Requirements
- R1: After reset, and whenever `busy` is low, `txd` = 1, `sclk` = 1 and `busy` = 0. Asserting reset during a frame returns the outputs to this state.
- R2: A clock edge with `ld_valid` = 1 and `busy` = 0 accepts a load, and `busy` is 1 from the next cycle on. `ld_data` and all `cfg_*` inputs are captured at that edge, and later changes to them do not affect the frame. Until the first tick after acceptance, `txd` stays 1.
- R3: In asynchronous mode (`cfg_sync` = 0), the first tick after acceptance drives the start bit (`txd` = 0). Each later tick moves to the next bit. Data bits are sent starting from `ld_data[0]` and going upward.
- R4: `cfg_len` selects the asynchronous data length: 0 gives 7 bits, 1 gives 8, 2 gives 9, and 3 gives 8.
- R5: With `cfg_par_en` = 1, one parity bit follows the data bits. Its value is the XOR of the sent data bits when `cfg_par_odd` = 0 (even), and the inverse of that XOR when `cfg_par_odd` = 1 (odd). With `cfg_par_en` = 0, no parity bit is sent.
- R6: Each stop bit has `txd` = 1. `cfg_two_stop` = 0 sends one stop bit and 1 sends two.
- R7: With `cfg_sync` = 1, exactly eight bits `ld_data[7:0]` are sent, LSB first, with no start, parity or stop bits, and `cfg_len`, `cfg_par_en` and `cfg_two_stop` are ignored. On odd-numbered ticks (1, 3, …, 15) `sclk` falls and `txd` takes the next bit. On even-numbered ticks `sclk` rises and `txd` holds.
- R8: `busy` falls, and `txd` returns to 1, on the tick that ends the last stop bit, or on the 16th tick in synchronous mode.
- R9: A load offered while `busy` = 1 is ignored: the current frame continues unchanged, and no frame follows it.
- R10: While `busy` = 1 and `bit_tick` = 0, `txd`, `sclk` and `busy` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_valid | input | 1 | Load request for `ld_data` |
| ld_data | input | 9 | Word to send (bit 0 goes out first) |
| cfg_sync | input | 1 | 1 = clock-synchronous mode |
| cfg_len | input | 2 | Asynchronous data length code |
| cfg_par_en | input | 1 | Parity bit enable |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| cfg_two_stop | input | 1 | 1 = two stop bits |
| bit_tick | input | 1 | Bit-rate enable, one cycle wide |
| busy | output | 1 | Frame in progress |
| txd | output | 1 | Serial data line |
| sclk | output | 1 | Shift clock (synchronous mode) |

## Verification
The hardest case to reach is a load request, or a change to the mode inputs, that arrives in the middle of a frame. To show it has no effect, the bench needs a frame whose remaining bits would differ if the new word or mode were taken. The bench starts a nine-bit frame, then mid-frame raises `ld_valid` with a different word and flips the parity and stop settings. It checks every remaining bit against the original frame, then ticks again after the end to confirm that no second frame begins. Pauses with no tick are placed both before the start bit and inside a frame, to show that every output holds.

// File: rtl/sft_pkg.sv
package sft_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_SYNC
    } sft_state_e;

    localparam logic [1:0] LEN_SHORT = 2'd0;
    localparam logic [1:0] LEN_MID   = 2'd1;
    localparam logic [1:0] LEN_LONG  = 2'd2;

endpackage

// File: rtl/sft_parity.sv
module sft_parity #(
    parameter int DATA_W = 9,
    localparam int CNT_W = $clog2(DATA_W + 1)
) (
    input  logic [DATA_W-1:0] data,
    input  logic [CNT_W-1:0]  nbits,
    input  logic              odd,
    output logic              par_bit
);

    always_comb begin
        logic acc;
        acc = odd;
        for (int i = 0; i < DATA_W; i++) begin
            if (CNT_W'(i) < nbits) begin
                acc = acc ^ data[i];
            end
        end
        par_bit = acc;
    end

endmodule

// File: rtl/sft_core.sv
module sft_core
    import sft_pkg::*;
#(
    parameter int DATA_W    = 9,
    parameter int SYNC_BITS = 8,
    localparam int CNT_W    = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_valid,
    input  logic [DATA_W-1:0] ld_data,
    input  logic [CNT_W-1:0]  nbits,
    input  logic              par_bit,
    input  logic              cfg_sync,
    input  logic              cfg_par_en,
    input  logic              cfg_two_stop,
    input  logic              bit_tick,
    output logic              busy,
    output logic              txd,
    output logic              sclk
);

    typedef struct packed {
        sft_state_e        st;
        logic [DATA_W-1:0] sh;
        logic [CNT_W-1:0]  cnt;
        logic [CNT_W-1:0]  nbits;
        logic              sync;
        logic              par_en;
        logic              par_bit;
        logic              two_stop;
        logic              stop_second;
        logic              sclk;
        logic              txd;
        logic              busy;
    } regs_t;

    localparam regs_t RST = '{
        st:          ST_IDLE,
        sh:          '0,
        cnt:         '0,
        nbits:       '0,
        sync:        1'b0,
        par_en:      1'b0,
        par_bit:     1'b0,
        two_stop:    1'b0,
        stop_second: 1'b0,
        sclk:        1'b1,
        txd:         1'b1,
        busy:        1'b0
    };

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (ld_valid) begin
                    r_d.st          = ST_ARM;
                    r_d.busy        = 1'b1;
                    r_d.sh          = ld_data;
                    r_d.cnt         = '0;
                    r_d.nbits       = cfg_sync ? CNT_W'(SYNC_BITS) : nbits;
                    r_d.sync        = cfg_sync;
                    r_d.par_en      = cfg_par_en & ~cfg_sync;
                    r_d.par_bit     = par_bit;
                    r_d.two_stop    = cfg_two_stop;
                    r_d.stop_second = 1'b0;
                end
            end
            ST_ARM: begin
                if (bit_tick) begin
                    if (r_q.sync) begin
                        r_d.st   = ST_SYNC;
                        r_d.sclk = 1'b0;
                        r_d.txd  = r_q.sh[0];
                        r_d.sh   = {1'b0, r_q.sh[DATA_W-1:1]};
                        r_d.cnt  = CNT_W'(1);
                    end else begin
                        r_d.st  = ST_START;
                        r_d.txd = 1'b0;
                    end
                end
            end
            ST_START: begin
                if (bit_tick) begin
                    r_d.st  = ST_DATA;
                    r_d.txd = r_q.sh[0];
                    r_d.sh  = {1'b0, r_q.sh[DATA_W-1:1]};
                    r_d.cnt = CNT_W'(1);
                end
            end
            ST_DATA: begin
                if (bit_tick) begin
                    if (r_q.cnt == r_q.nbits) begin
                        if (r_q.par_en) begin
                            r_d.st  = ST_PAR;
                            r_d.txd = r_q.par_bit;
                        end else begin
                            r_d.st  = ST_STOP;
                            r_d.txd = 1'b1;
                        end
                    end else begin
                        r_d.txd = r_q.sh[0];
                        r_d.sh  = {1'b0, r_q.sh[DATA_W-1:1]};
                        r_d.cnt = r_q.cnt + CNT_W'(1);
                    end
                end
            end
            ST_PAR: begin
                if (bit_tick) begin
                    r_d.st  = ST_STOP;
                    r_d.txd = 1'b1;
                end
            end
            ST_STOP: begin
                if (bit_tick) begin
                    if (r_q.two_stop && !r_q.stop_second) begin
                        r_d.stop_second = 1'b1;
                    end else begin
                        r_d.st   = ST_IDLE;
                        r_d.busy = 1'b0;
                    end
                end
            end
            ST_SYNC: begin
                if (bit_tick) begin
                    if (!r_q.sclk) begin
                        r_d.sclk = 1'b1;
                        if (r_q.cnt == r_q.nbits) begin
                            r_d.st   = ST_IDLE;
                            r_d.busy = 1'b0;
                            r_d.txd  = 1'b1;
                        end
                    end else begin
                        r_d.sclk = 1'b0;
                        r_d.txd  = r_q.sh[0];
                        r_d.sh   = {1'b0, r_q.sh[DATA_W-1:1]};
                        r_d.cnt  = r_q.cnt + CNT_W'(1);
                    end
                end
            end
            default: r_d = RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= RST;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy = r_q.busy;
    assign txd  = r_q.txd;
    assign sclk = r_q.sclk;

endmodule

// File: rtl/serial_frame_tx.sv
module serial_frame_tx
    import sft_pkg::*;
#(
    parameter int DATA_W    = 9,
    parameter int SYNC_BITS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_valid,
    input  logic [DATA_W-1:0] ld_data,
    input  logic              cfg_sync,
    input  logic [1:0]        cfg_len,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic              cfg_two_stop,
    input  logic              bit_tick,
    output logic              busy,
    output logic              txd,
    output logic              sclk
);

    localparam int CNT_W = $clog2(DATA_W + 1);

    logic [CNT_W-1:0] len_bits;
    logic             par_bit;

    always_comb begin
        unique case (cfg_len)
            LEN_SHORT: len_bits = CNT_W'(DATA_W - 2);
            LEN_LONG:  len_bits = CNT_W'(DATA_W);
            default:   len_bits = CNT_W'(DATA_W - 1);
        endcase
    end

    sft_parity #(.DATA_W(DATA_W)) u_par (
        .data    (ld_data),
        .nbits   (len_bits),
        .odd     (cfg_par_odd),
        .par_bit (par_bit)
    );

    sft_core #(.DATA_W(DATA_W), .SYNC_BITS(SYNC_BITS)) u_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .ld_valid     (ld_valid),
        .ld_data      (ld_data),
        .nbits        (len_bits),
        .par_bit      (par_bit),
        .cfg_sync     (cfg_sync),
        .cfg_par_en   (cfg_par_en),
        .cfg_two_stop (cfg_two_stop),
        .bit_tick     (bit_tick),
        .busy         (busy),
        .txd          (txd),
        .sclk         (sclk)
    );

endmodule

// File: rtl/sft_chk.sv
module sft_chk (
    input logic clk,
    input logic rst_n,
    input logic ld_valid,
    input logic bit_tick,
    input logic busy,
    input logic txd,
    input logic sclk
);

    // R1
    idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (txd && sclk));

    // R2
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(ld_valid));

    // R10
    hold_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !bit_tick) |=> ($stable(txd) && $stable(sclk) && busy));

    // R8
    busy_fall_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(bit_tick));

    // R3
    start_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(txd) |-> ($past(bit_tick) && busy));

    // R7
    sclk_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sclk) |-> ($past(bit_tick) && busy));

endmodule

bind serial_frame_tx sft_chk u_sft_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_valid (ld_valid),
    .bit_tick (bit_tick),
    .busy     (busy),
    .txd      (txd),
    .sclk     (sclk)
);

// File: tb/tb_serial_frame_tx.sv
module tb_serial_frame_tx;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ld_valid = 1'b0;
    logic [8:0] ld_data = '0;
    logic       cfg_sync = 1'b0;
    logic [1:0] cfg_len = 2'd1;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_odd = 1'b0;
    logic       cfg_two_stop = 1'b0;
    logic       bit_tick = 1'b0;
    logic       busy, txd, sclk;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    serial_frame_tx dut (
        .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_data(ld_data),
        .cfg_sync(cfg_sync), .cfg_len(cfg_len), .cfg_par_en(cfg_par_en),
        .cfg_par_odd(cfg_par_odd), .cfg_two_stop(cfg_two_stop),
        .bit_tick(bit_tick), .busy(busy), .txd(txd), .sclk(sclk)
    );

    // {sync, len[1:0], par_en, par_odd, two_stop, data[8:0]}
    localparam logic [14:0] VEC [8] = '{
        {1'b0, 2'd1, 1'b0, 1'b0, 1'b0, 9'h0A5},
        {1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 9'h0FF},
        {1'b0, 2'd2, 1'b1, 1'b1, 1'b1, 9'h1C3},
        {1'b0, 2'd3, 1'b1, 1'b0, 1'b1, 9'h181},
        {1'b0, 2'd1, 1'b1, 1'b1, 1'b0, 9'h000},
        {1'b1, 2'd2, 1'b1, 1'b1, 1'b1, 9'h13C},
        {1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 9'h0A5},
        {1'b0, 2'd2, 1'b0, 1'b0, 1'b1, 9'h155}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk) bit_tick = 1'b1;
        @(negedge clk) bit_tick = 1'b0;
    endtask

    task automatic idle_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic load(input logic [14:0] v);
        @(negedge clk);
        {cfg_sync, cfg_len, cfg_par_en, cfg_par_odd, cfg_two_stop, ld_data} = v;
        ld_valid = 1'b1;
        @(negedge clk);
        ld_valid = 1'b0;
        chk("R2 busy after load", 16'(busy), 16'd1);
        chk("R2 line high before first tick", 16'(txd), 16'd1);
    endtask

    // expected asynchronous frame, built from the requirements
    task automatic build_async(input logic [14:0] v, output logic [15:0] bits,
                               output string tags [16], output int len);
        logic [1:0] lc;
        logic [8:0] d;
        int n;
        logic p;
        lc = v[13:12];
        d  = v[8:0];
        n  = (lc == 2'd0) ? 7 : (lc == 2'd2) ? 9 : 8;
        len = 0;
        bits = '0;
        bits[len] = 1'b0; tags[len] = "R3 start"; len++;
        p = v[10];
        for (int i = 0; i < n; i++) begin
            bits[len] = d[i];
            p = p ^ d[i];
            tags[len] = "R4 data bit";
            len++;
        end
        if (v[11]) begin
            bits[len] = p; tags[len] = "R5 parity"; len++;
        end
        bits[len] = 1'b1; tags[len] = "R6 stop"; len++;
        if (v[9]) begin
            bits[len] = 1'b1; tags[len] = "R6 second stop"; len++;
        end
    endtask

    task automatic run_async(input logic [14:0] v, input bit disturb);
        logic [15:0] bits;
        string tags [16];
        int len;
        build_async(v, bits, tags, len);
        load(v);
        for (int k = 0; k < len; k++) begin
            tick();
            chk(tags[k], 16'(txd), 16'(bits[k]));
            chk("R8 busy during frame", 16'(busy), 16'd1);
            if (disturb && k == 3) begin
                // R9: a new load and new config mid-frame must change nothing
                ld_data = ~v[8:0];
                cfg_par_en = ~v[11];
                cfg_two_stop = ~v[9];
                cfg_len = 2'd0;
                ld_valid = 1'b1;
                idle_cycles(3);
                ld_valid = 1'b0;
                chk("R9 load ignored while busy", 16'(busy), 16'd1);
            end
            if (disturb && k == 1) begin
                idle_cycles(5);
                chk("R10 line holds without tick", 16'(txd), 16'(bits[k]));
            end
        end
        tick();
        chk("R8 busy falls after last stop", 16'(busy), 16'd0);
        chk("R8 line back high", 16'(txd), 16'd1);
    endtask

    task automatic run_sync(input logic [14:0] v);
        load(v);
        for (int k = 0; k < 16; k++) begin
            tick();
            chk("R7 sclk phase", 16'(sclk), 16'(k % 2));
            if (k < 15) begin
                chk("R7 sync data bit", 16'(txd), 16'(v[k / 2]));
                chk("R7 busy in sync", 16'(busy), 16'd1);
            end else begin
                chk("R8 sync busy falls", 16'(busy), 16'd0);
                chk("R8 sync line high", 16'(txd), 16'd1);
            end
        end
    endtask

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        idle_cycles(3);
        rst_n = 1'b1;
        idle_cycles(2);
        chk("R1 reset txd", 16'(txd), 16'd1);
        chk("R1 reset sclk", 16'(sclk), 16'd1);
        chk("R1 reset busy", 16'(busy), 16'd0);

        for (int i = 0; i < 8; i++) begin
            if (VEC[i][14]) run_sync(VEC[i]);
            else run_async(VEC[i], 1'b0);
        end

        // R10: pending load, no tick yet, line stays high
        load({1'b0, 2'd1, 1'b0, 1'b0, 1'b0, 9'h0F0});
        idle_cycles(6);
        chk("R10 waits for tick", 16'(txd), 16'd1);
        chk("R10 busy held", 16'(busy), 16'd1);
        tick();
        chk("R3 start after wait", 16'(txd), 16'd0);
        // R1: reset mid-frame
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk);
        chk("R1 reset mid-frame busy", 16'(busy), 16'd0);
        chk("R1 reset mid-frame txd", 16'(txd), 16'd1);
        rst_n = 1'b1;
        idle_cycles(2);

        // R9 and R2: disturbance during a 9-bit odd-parity frame
        run_async({1'b0, 2'd2, 1'b1, 1'b1, 1'b0, 9'h0B7}, 1'b1);
        tick();
        chk("R9 no frame follows ignored load", 16'(busy), 16'd0);
        chk("R9 line idle", 16'(txd), 16'd1);

        // back-to-back loads
        run_async({1'b0, 2'd1, 1'b1, 1'b0, 1'b1, 9'h03C}, 1'b0);
        run_sync({1'b1, 2'd1, 1'b0, 1'b0, 1'b0, 9'h1FE});

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule